// File: doc/BRIEF.md
# Overwriting Dual-Clock Pixel Queue

This block moves 24-bit camera pixels from a slow capture clock into an unrelated, faster processing clock. The capture side offers a pixel with a one-cycle strobe and is never stalled. The processing side takes pixels from a valid/ready stream whose valid is registered.

When the capture side outruns the consumer and storage is full, the queue behaves as a ring. Each new pixel takes the slot of the oldest stored pixel. The overwrite is recorded by a drop count kept in the capture domain, and the processing side adds that count to its read position. Only data crosses between the domains; the sole bookkeeping that crosses is three Gray-coded counters (writes, drops, pops), each passed through a multi-flop synchroniser. A sticky flag in the capture domain reports that at least one pixel was lost, and a synchronous clear input resets it.

The intended use sits between a camera capture block (about 6.9 Mpixel/s on a 24 MHz clock) and a processing pipeline running at 50 MHz. Under normal load nothing is lost. Under a stalled consumer the newest pixels survive.

Top module: `pix_ring_cdc`

## Requirements
- R1: After both resets, `rd_valid` is 0 and `ovf_flag` is 0.
- R2: When the consumer keeps up, every written pixel appears once on `rd_pixel`, in write order, with all 24 bits unchanged, for any pattern of write gaps and `rd_ready` stalls.
- R3: Once `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_pixel` keeps its value on the next read clock.
- R4: With the consumer stalled, the queue holds DEPTH pixels in storage plus one in the output register without losing any, and `ovf_flag` stays 0. The output register shows the first pixel written.
- R5: A pixel written while storage is full replaces the oldest stored pixel. After K such overwrites with a stalled consumer, the consumer receives the pixel already in its output register, then the newest DEPTH pixels in order.
- R6: `ovf_flag` becomes 1 on the write clock after any overwrite and stays 1 until cleared; writes that do not overwrite do not set it.
- R7: `ovf_clr` high on a write clock clears `ovf_flag`, unless an overwrite happens on that same clock, in which case the flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Capture-domain clock |
| wr_rst_n | input | 1 | Capture-domain synchronous active-low reset |
| wr_valid | input | 1 | Pixel strobe; one pixel per high cycle |
| wr_pixel | input | 24 | Pixel written when `wr_valid` is 1 |
| ovf_clr | input | 1 | Synchronous clear of the overflow flag |
| ovf_flag | output | 1 | Sticky: set when a stored pixel was overwritten |
| rd_clk | input | 1 | Processing-domain clock |
| rd_rst_n | input | 1 | Processing-domain synchronous active-low reset |
| rd_valid | output | 1 | Registered valid of the output stream |
| rd_ready | input | 1 | Consumer accepts the pixel on this clock |
| rd_pixel | output | 24 | Output pixel |

## Verification
The in-order path is driven with three patterns: continuous writes with an always-ready consumer, strobes with gaps against a consumer that stalls one cycle in three, and back-to-back writes against that same stalling consumer. The first shows the basic pointer crossing. The second and third show that stalls and sparse strobes neither lose nor repeat pixels. A paced fill of DEPTH+1 pixels against a stalled consumer separates true capacity from a premature drop. An overfill of five, then one more overwrite under a simultaneous clear, shows which pixels survive, how the drop count is applied on the read side, and how set and clear are prioritised.

// File: rtl/pxq_pkg.sv
// Shared definitions for the overwriting dual-clock pixel queue.
// Assumes pixels are packed colour words of fixed width.
package pxq_pkg;
    localparam int PIX_W = 24;
    typedef logic [PIX_W-1:0] pixel_t;
endpackage

// File: rtl/pxq_gray_sync.sv
// Carries a Gray-coded counter into another clock domain through a chain
// of flops and decodes it back to binary.
// Assumes the source changes the value by at most one step per source clock.
module pxq_gray_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage_q [STAGES];

    // Synchroniser chain: first flop samples the foreign value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= gray_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    // Gray to binary: each bit is the parity of the bits at and above it.
    for (genvar b = 0; b < W; b++) begin : g_dec
        assign bin_out[b] = ^stage_q[STAGES-1][W-1:b];
    end
endmodule

// File: rtl/pxq_ring_mem.sv
// Pixel storage: written in the capture domain, read asynchronously
// by the processing domain's output register.
// Assumes the reader never addresses a slot being written in the same cycle
// except under overwrite, where either value is acceptable.
module pxq_ring_mem #(
    parameter int DW = 24,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int SLOTS = 1 << AW;

    logic [DW-1:0] slot_q [SLOTS];

    // Store one pixel per strobe.
    always_ff @(posedge wclk) begin
        if (we) slot_q[waddr] <= wdata;
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/pxq_wr_ctrl.sv
// Capture-domain control: advances the write counter, decides fullness from
// the synchronised pop count plus its own drop count, counts overwrites and
// keeps the sticky overflow flag.
// Assumes pops_bin never runs ahead of what was actually popped.
module pxq_wr_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          ovf_clr,
    input  logic [PW-1:0] pops_bin,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wptr_gray,
    output logic [PW-1:0] drop_gray,
    output logic          ovf_flag
);
    logic [PW-1:0] wptr_q, drops_q;
    logic [PW-1:0] oldest, occ, wptr_nx, drops_nx;
    logic          full, drop_now;

    // Fullness from the write domain's view of the oldest live slot.
    always_comb begin
        oldest   = pops_bin + drops_q;
        occ      = wptr_q - oldest;
        full     = !occ[PW-1] && (occ >= PW'(DEPTH));
        drop_now = wr_valid && full;
        wptr_nx  = wptr_q + {{(PW-1){1'b0}}, wr_valid};
        drops_nx = drops_q + {{(PW-1){1'b0}}, drop_now};
    end

    assign we    = wr_valid;
    assign waddr = wptr_q[AW-1:0];

    // Counters and their Gray images published to the read domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q    <= '0;
            drops_q   <= '0;
            wptr_gray <= '0;
            drop_gray <= '0;
        end else begin
            wptr_q    <= wptr_nx;
            drops_q   <= drops_nx;
            wptr_gray <= wptr_nx ^ (wptr_nx >> 1);
            drop_gray <= drops_nx ^ (drops_nx >> 1);
        end
    end

    // Sticky overflow: an overwrite beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (drop_now) ovf_flag <= 1'b1;
        else if (ovf_clr)  ovf_flag <= 1'b0;
    end

    a_r5_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !occ[PW-1] |-> occ <= PW'(DEPTH));
    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full) |=> ovf_flag);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(wr_valid && full)) |=> !ovf_flag);
    a_r2_wptr_gray: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(wptr_gray ^ $past(wptr_gray)) <= 1);
    a_r5_drop_gray: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(drop_gray ^ $past(drop_gray)) <= 1);
endmodule

// File: rtl/pxq_rd_ctrl.sv
// Processing-domain control: read position is pops plus synchronised drops,
// so overwritten slots are skipped; a registered output stage presents data.
// Assumes wptr_bin and drops_bin come from Gray synchronisers.
module pxq_rd_ctrl #(
    parameter int DW = 24,
    parameter int AW = 4,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wptr_bin,
    input  logic [PW-1:0] drops_bin,
    input  logic [DW-1:0] mem_data,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] pops_gray,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    logic [PW-1:0] pops_q, pos, fill, pops_nx;
    logic          avail, load;

    // Next slot to read and whether a pixel is waiting there.
    always_comb begin
        pos     = pops_q + drops_bin;
        fill    = wptr_bin - pos;
        avail   = !fill[PW-1] && (fill != '0);
        load    = avail && (!out_valid || out_ready);
        pops_nx = pops_q + {{(PW-1){1'b0}}, load};
    end

    assign raddr = pos[AW-1:0];

    // Pop counter and its Gray image for the write domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pops_q    <= '0;
            pops_gray <= '0;
        end else begin
            pops_q    <= pops_nx;
            pops_gray <= pops_nx ^ (pops_nx >> 1);
        end
    end

    // Output register: load on free slot, drop valid when taken and nothing new.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= mem_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r2_pop_gray: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(pops_gray ^ $past(pops_gray)) <= 1);
endmodule

// File: rtl/pix_ring_cdc.sv
// Overwriting dual-clock pixel queue. Capture side never stalls; on full the
// oldest stored pixel is replaced and a sticky flag is raised. Only Gray
// counters cross domains.
// Assumes DEPTH is a power of two and both resets are applied together.
module pix_ring_cdc #(
    parameter int DATA_W      = pxq_pkg::PIX_W,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_pixel,
    input  logic              ovf_clr,
    output logic              ovf_flag,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_pixel
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 2;

    logic              we;
    logic [AW-1:0]     waddr, raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PW-1:0]     wptr_gray, drop_gray, pops_gray;
    logic [PW-1:0]     wptr_rd, drops_rd, pops_wr;

    pxq_ring_mem #(.DW(DATA_W), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_pixel),
        .raddr(raddr), .rdata(mem_rdata)
    );

    pxq_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_valid(wr_valid), .ovf_clr(ovf_clr),
        .pops_bin(pops_wr), .we(we), .waddr(waddr), .wptr_gray(wptr_gray),
        .drop_gray(drop_gray), .ovf_flag(ovf_flag)
    );

    pxq_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_wptr (
        .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wptr_gray), .bin_out(wptr_rd)
    );

    pxq_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_drop (
        .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(drop_gray), .bin_out(drops_rd)
    );

    pxq_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_pops (
        .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(pops_gray), .bin_out(pops_wr)
    );

    pxq_rd_ctrl #(.DW(DATA_W), .AW(AW), .PW(PW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .wptr_bin(wptr_rd), .drops_bin(drops_rd),
        .mem_data(mem_rdata), .raddr(raddr), .pops_gray(pops_gray),
        .out_valid(rd_valid), .out_ready(rd_ready), .out_data(rd_pixel)
    );
endmodule

// File: tb/pix_ring_cdc_bench.sv
`timescale 1ns/1ps
module pix_ring_cdc_bench;
    localparam int D = 16;

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic        wr_valid = 1'b0, ovf_clr = 1'b0, rd_ready = 1'b0;
    logic [23:0] wr_pixel = '0;
    logic        ovf_flag, rd_valid;
    logic [23:0] rd_pixel;

    always #10 rd_clk = ~rd_clk;
    initial begin
        #3.1;
        forever #20.833 wr_clk = ~wr_clk;
    end

    pix_ring_cdc u_pix_ring_cdc (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid),
        .wr_pixel(wr_pixel), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_pixel(rd_pixel)
    );

    int          checks = 0, fails = 0, rd_mode = 0, rcyc = 0;
    string       cur_req = "R2";
    logic [23:0] exp_q[$];
    logic        pv = 1'b0, pr = 1'b0;
    logic [23:0] pd = '0, e_px;

    function automatic logic [23:0] pix(int i);
        return {8'(i * 7 + 145), 8'(~i), 8'(i + 60)};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each accepted pixel against the scoreboard; drive ready.
    always @(negedge rd_clk) begin
        if (rd_rst_n) begin
            if (pv && pr) begin
                if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected pixel", pd, 0);
                else begin
                    e_px = exp_q.pop_front();
                    chk(pd == e_px, cur_req, "pixel order/value", pd, e_px);
                end
            end
            if (pv && !pr)
                chk(rd_valid && rd_pixel == pd, "R3", "held pixel", rd_pixel, pd);
        end
        case (rd_mode)
            0: rd_ready = 1'b0;
            1: rd_ready = 1'b1;
            default: rd_ready = (rcyc % 3) != 0;
        endcase
        pv = rd_valid;
        pd = rd_pixel;
        pr = rd_ready;
        rcyc++;
    end

    // Driver: write n pixels, optionally with a gap after each, pushing expectations.
    task automatic wr_burst(int first, int n, bit push, bit gaps);
        for (int k = 0; k < n; k++) begin
            @(negedge wr_clk);
            wr_valid = 1'b1;
            wr_pixel = pix(first + k);
            if (push) exp_q.push_back(pix(first + k));
            if (gaps) begin
                @(negedge wr_clk);
                wr_valid = 1'b0;
            end
        end
        @(negedge wr_clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain(string req);
        repeat (200) @(negedge rd_clk);
        chk(exp_q.size() == 0, req, "pixels missing", exp_q.size(), 0);
        chk(rd_valid == 1'b0, req, "valid after drain", rd_valid, 0);
    endtask

    task automatic wait_w(int n);
        repeat (n) @(negedge wr_clk);
    endtask

    initial begin
        repeat (8) @(negedge rd_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (4) @(negedge rd_clk);
        chk(rd_valid == 1'b0, "R1", "valid after reset", rd_valid, 0);
        chk(ovf_flag == 1'b0, "R1", "flag after reset", ovf_flag, 0);

        // R2: continuous writes, consumer always ready
        cur_req = "R2"; rd_mode = 1;
        wr_burst(0, 30, 1'b1, 1'b0);
        drain("R2");
        // R2: gapped strobes, consumer stalls one cycle in three
        rd_mode = 2;
        wr_burst(100, 40, 1'b1, 1'b1);
        drain("R2");
        // R2: back-to-back strobes against the stalling consumer
        wr_burst(200, 40, 1'b1, 1'b0);
        drain("R2");
        chk(ovf_flag == 1'b0, "R6", "flag without overwrite", ovf_flag, 0);

        // R4: capacity DEPTH + output register, no loss
        cur_req = "R4"; rd_mode = 0;
        wr_burst(300, 1, 1'b1, 1'b0);
        wait_w(20);
        wr_burst(301, D, 1'b1, 1'b0);
        wait_w(20);
        chk(ovf_flag == 1'b0, "R4", "flag at exact capacity", ovf_flag, 0);
        @(negedge rd_clk);
        chk(rd_valid && rd_pixel == pix(300), "R4", "head in output", rd_pixel, pix(300));
        rd_mode = 1;
        drain("R4");

        // R5/R6: overfill by five with consumer stalled
        cur_req = "R5"; rd_mode = 0;
        wr_burst(400, 1, 1'b1, 1'b0);
        wait_w(20);
        wr_burst(401, D + 5, 1'b0, 1'b0);
        wait_w(20);
        chk(ovf_flag == 1'b1, "R6", "flag after overwrite", ovf_flag, 1);
        wait_w(30);
        chk(ovf_flag == 1'b1, "R6", "flag sticky", ovf_flag, 1);
        // R7: plain clear
        @(negedge wr_clk); ovf_clr = 1'b1;
        @(negedge wr_clk); ovf_clr = 1'b0;
        chk(ovf_flag == 1'b0, "R7", "flag cleared", ovf_flag, 0);
        // R7: clear together with an overwrite: set wins
        @(negedge wr_clk);
        ovf_clr = 1'b1; wr_valid = 1'b1; wr_pixel = pix(400 + D + 6);
        @(negedge wr_clk);
        ovf_clr = 1'b0; wr_valid = 1'b0;
        chk(ovf_flag == 1'b1, "R7", "set beats clear", ovf_flag, 1);
        wait_w(20);
        @(negedge rd_clk);
        chk(rd_valid && rd_pixel == pix(400), "R5", "output register kept", rd_pixel, pix(400));
        for (int j = 7; j <= D + 6; j++) exp_q.push_back(pix(400 + j));
        rd_mode = 1;
        drain("R5");

        // R2: recovery after overflow
        @(negedge wr_clk); ovf_clr = 1'b1;
        @(negedge wr_clk); ovf_clr = 1'b0;
        cur_req = "R2";
        wr_burst(500, 20, 1'b1, 1'b0);
        drain("R2");
        chk(ovf_flag == 1'b0, "R6", "no spurious flag", ovf_flag, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge rd_clk);
        checks++; fails++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule